// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block is a bus-mapped general-purpose I/O port for eight pins whose pads are also routed to an analog converter's inputs. Software programs an output value, a per-pin direction and a per-pin reduced-drive choice. The block turns these into an output value, an output enable and a drive-strength select for each pad.

Each pin's input is brought into the clock domain through a two-flop synchronizer. It is then masked by a digital-input-enable vector that the converter block supplies, because a pin that is being used as an analog input should not feed the digital logic. When software reads the data address, each bit returns the latched output value if that pin is an output. If the pin is an input, the bit returns the synchronized and masked pin level.

Top module: `anpin_gpio_port`

## Requirements
- R1: After reset the data, direction and reduced-drive registers hold 0. pin_oe, pin_lowdrv, pin_out and bus_rdata are then all 0.
- R2: A cycle with bus_sel=1 and bus_wr=1 writes bus_wdata into a register at that clock edge. The register is chosen by address: 0 is data, 1 is direction and 2 is reduced drive. A cycle with bus_sel=1 and bus_wr=0 places the addressed value on bus_rdata at that edge, so it is visible in the next cycle.
- R3: pin_oe equals the direction register, where bit value 1 means output. pin_out equals the data register.
- R4: pin_lowdrv bit i is 1 only when the reduced-drive bit i and the direction bit i are both 1. A reduced-drive bit has no effect on an input pin.
- R5: Reading address 0 returns the data register bit for every pin whose direction bit is 1.
- R6: Reading address 0 returns, for every pin whose direction bit is 0, the synchronized pin level ANDed with din_en. A pin whose din_en bit is 0 reads as 0.
- R7: The pin input passes through two synchronizer stages. A level applied just before clock edge k is not returned by a read sampled at edge k or k+1. It is returned by a read sampled at edge k+2 or later.
- R8: Writes to the data register take effect whatever the direction setting. A value written while a pin is an input appears on pin_out and on readback once the pin is an output.
- R9: Address 3 reads as 0. A write to address 3 changes no register and no output.
- R10: bus_wr without bus_sel writes nothing. bus_rdata keeps its value in every cycle that is not a selected read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Access strobe for this port |
| bus_wr | input | 1 | 1 = write, 0 = read (valid with bus_sel) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Raw pad input levels (asynchronous) |
| din_en | input | 8 | Per-pin digital-input enable from the converter |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_lowdrv | output | 8 | Pad reduced-drive selects |

## Verification
The properties assume that bus_sel, bus_wr, bus_addr and bus_wdata are stable, known values around each rising edge. They also assume that reset is held for at least one edge before checks begin. The bench meets these conditions by changing every input only on the falling clock edge and by holding rst_n low for several cycles. pin_in and din_en are treated as free inputs, so no property depends on their timing. The bench still changes them on falling edges, so that the synchronizer latency can be counted exactly.

// File: rtl/anpin_gpio_pkg.sv
// Shared constants for the shared-pin GPIO port.
// Assumes: a 2-bit register address space with four slots.
package anpin_gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA  = 2'd0,
        REG_DIR   = 2'd1,
        REG_DRIVE = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/anpin_gpio_sync.sv
// Multi-stage synchronizer for the asynchronous pad inputs.
// Assumes: pad levels are quasi-static relative to clk; the bits need no mutual coherence.
module anpin_gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the pad levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/anpin_gpio_regs.sv
// Register file: output data, direction and reduced-drive registers with write decode.
// Assumes: bus strobes are synchronous to clk; address 3 holds no register.
module anpin_gpio_regs
    import anpin_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  data_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  drive_q
);
    // Update the addressed register on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            drive_q <= '0;
        end else if (wr_en) begin
            unique case (reg_sel_e'(wr_addr))
                REG_DATA:  data_q  <= wr_data;
                REG_DIR:   dir_q   <= wr_data;
                REG_DRIVE: drive_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/anpin_gpio_rdpath.sv
// Read path: per-bit readback selection and the registered read-data output.
// Assumes: sync_pins is already synchronized to clk.
module anpin_gpio_rdpath
    import anpin_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]  data_q,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  drive_q,
    input  logic [WIDTH-1:0]  sync_pins,
    input  logic [WIDTH-1:0]  din_en,
    output logic [WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] port_view;
    logic [WIDTH-1:0] rd_next;

    // Per pin: latched value for outputs, masked pad level for inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign port_view[i] = dir_q[i] ? data_q[i] : (sync_pins[i] & din_en[i]);
    end

    // Select the value for the addressed register.
    always_comb begin
        unique case (reg_sel_e'(rd_addr))
            REG_DATA:  rd_next = port_view;
            REG_DIR:   rd_next = dir_q;
            REG_DRIVE: rd_next = drive_q;
            default:   rd_next = '0;
        endcase
    end

    // Capture the read data on a selected read; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_next;
    end
endmodule

// File: rtl/anpin_gpio_port.sv
// Top: shared-pin GPIO port with bus access, pad controls and a synchronized input path.
// Assumes: the converter drives din_en; the pads are external to this block.
module anpin_gpio_port
    import anpin_gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    input  logic [WIDTH-1:0]  din_en,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_lowdrv
);
    logic [WIDTH-1:0] data_q, dir_q, drive_q, sync_pins;
    logic             wr_en, rd_en;

    assign wr_en = bus_sel &  bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    anpin_gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_pins)
    );

    anpin_gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .data_q(data_q), .dir_q(dir_q), .drive_q(drive_q)
    );

    anpin_gpio_rdpath #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(bus_addr),
        .data_q(data_q), .dir_q(dir_q), .drive_q(drive_q),
        .sync_pins(sync_pins), .din_en(din_en), .rdata(bus_rdata)
    );

    // Pad controls: enable follows direction, reduced drive only on outputs.
    assign pin_out    = data_q;
    assign pin_oe     = dir_q;
    assign pin_lowdrv = drive_q & dir_q;
endmodule

// File: rtl/anpin_gpio_chk.sv
// Checker for the shared-pin GPIO port; observes ports only.
// Assumes: bus inputs are known and stable around each rising edge.
module anpin_gpio_chk
    import anpin_gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic [WIDTH-1:0]  pin_in,
    input logic [WIDTH-1:0]  din_en,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_lowdrv
);
    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata)));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> (pin_oe == $past(bus_wdata)));

    // R4
    lowdrv_inputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lowdrv & ~pin_oe) == '0);

    // R9
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd3)
        |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_lowdrv)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

    // R10
    unsel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind anpin_gpio_port anpin_gpio_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_anpin_gpio_port.sv
module tb_anpin_gpio_port;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_sel = 0, bus_wr = 0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, pin_in = '0, din_en = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe, pin_lowdrv;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    anpin_gpio_port dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .din_en(din_en), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_lowdrv(pin_lowdrv)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata;
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 oe", pin_oe, 8'h00);
        check("R1 lowdrv", pin_lowdrv, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        bus_read(2'd1, v); check("R1 dir reg", v, 8'h00);
        bus_read(2'd2, v); check("R1 drive reg", v, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        bus_write(2'd1, 8'hA5);
        check("R3 oe", pin_oe, 8'hA5);
        bus_read(2'd1, v); check("R2 dir readback", v, 8'hA5);
        bus_write(2'd2, 8'h3C);
        bus_read(2'd2, v); check("R2 drive readback", v, 8'h3C);
        check("R4 lowdrv", pin_lowdrv, 8'h24);
        bus_write(2'd0, 8'h5A);
        check("R3 out", pin_out, 8'h5A);
    endtask

    task automatic t_mixed_read();
        logic [7:0] v;
        // dir=A5, data=5A; pins all high, enable all
        pin_in = 8'hFF; din_en = 8'hFF; settle(3);
        bus_read(2'd0, v);
        check("R5/R6 mixed", v, (8'h5A & 8'hA5) | (8'hFF & ~8'hA5));
        din_en = 8'h0F; settle(1);
        bus_read(2'd0, v);
        check("R6 din_en mask", v, (8'h5A & 8'hA5) | (8'h0F & ~8'hA5));
    endtask

    task automatic t_sync();
        logic [7:0] v;
        bus_write(2'd1, 8'h00);
        din_en = 8'hFF; pin_in = 8'h00; settle(3);
        @(negedge clk);
        pin_in = 8'hC3; bus_sel = 1; bus_wr = 0; bus_addr = 2'd0;
        @(negedge clk); check("R7 edge k", bus_rdata, 8'h00);
        @(negedge clk); check("R7 edge k+1", bus_rdata, 8'h00);
        @(negedge clk); check("R7 edge k+2", bus_rdata, 8'hC3);
        bus_sel = 0;
    endtask

    task automatic t_data_while_input();
        logic [7:0] v;
        pin_in = 8'h00; settle(3);
        bus_write(2'd0, 8'h96);
        check("R8 out while input", pin_out, 8'h96);
        bus_read(2'd0, v); check("R8 reads pins", v, 8'h00);
        bus_write(2'd1, 8'hFF);
        bus_read(2'd0, v); check("R8 reads data", v, 8'h96);
        check("R4 all out lowdrv", pin_lowdrv, 8'h3C);
    endtask

    task automatic t_hole_and_unsel();
        logic [7:0] v;
        bus_write(2'd3, 8'hFF);
        check("R9 out kept", pin_out, 8'h96);
        check("R9 oe kept", pin_oe, 8'hFF);
        bus_read(2'd3, v); check("R9 reads zero", v, 8'h00);
        bus_read(2'd2, v);
        check("R9 drive kept", v, 8'h3C);
        @(negedge clk);
        bus_sel = 0; bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h11;
        @(negedge clk); bus_wr = 0;
        check("R10 unselected write", pin_out, 8'h96);
        settle(2);
        check("R10 rdata holds", bus_rdata, 8'h3C);
    endtask

    initial begin
        settle(4);
        rst_n = 1;
        t_reset();
        t_regs();
        t_mixed_read();
        t_sync();
        t_data_while_input();
        t_hole_and_unsel();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule